// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block reproduces, cycle by cycle, the column sequence that a synchronous DRAM walks through internally during a read or write burst. A controller or a memory scoreboard feeds it the same command stream it sends to the memory (a start column, the programmed burst length and ordering, the write-burst policy, clock-suspend and burst-stop events), and the block reports which column each data beat belongs to, whether a beat is consumed in that cycle, and whether that beat closes the burst.

The column address is 8 bits wide, one row holding 256 columns. Bursts of 1, 2, 4 or 8 beats stay inside an aligned block of that size, in either a sequential (wrapping increment) or an interleaved (XOR) order. A full-row burst runs in sequential order only, wraps around the row without end, and is closed only by a burst stop. A later valid command always replaces the burst in progress.

Top module: `sdram_col_gen`

## Requirements
- R1: While the internal reset is active, `beat_valid` and `last_beat` are low; after reset no beat is reported until a command is accepted.
- R2: A command is accepted when `cmd_valid` is high and its settings are legal; in the following cycle `col` equals the start column and `beat_valid` is high (unless suspended).
- R3: In sequential order (`interleave`=0) beat k shows the start column with its low log2(L) bits replaced by (start + k) mod L, for burst length L; the upper bits never change during the burst.
- R4: In interleaved order (`interleave`=1) beat k shows the start column XOR k, for k from 0 to L-1.
- R5: `len_sel` codes 0, 1, 2, 3 give bursts of 1, 2, 4, 8 beats; `last_beat` is high on beat L-1 only, and the cycle after it no beat is valid.
- R6: `len_sel` code 7 selects a full-row sequential burst: the column increments modulo 256 indefinitely and `last_beat` stays low while no burst stop is given.
- R7: A command with `interleave`=1 and `len_sel`=7, or with a reserved `len_sel` code (4, 5, 6), is ignored: no burst starts from idle and a burst in progress continues unchanged.
- R8: A write (`cmd_write`=1) issued while `single_write`=1 is a single beat with `last_beat` high, whatever `len_sel` says; reads keep the programmed length.
- R9: While `suspend` is high during a burst, `col` holds its value, `beat_valid` is low and the beat index does not advance; the held column is repeated when `suspend` falls.
- R10: `burst_stop` during a burst raises `last_beat` in that cycle (even when suspended) and leaves the generator idle in the next cycle.
- R11: An accepted command arriving during a burst restarts the generator at the new start column in the next cycle, taking priority over a simultaneous burst stop or suspend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | A read or write command is issued this cycle |
| cmd_write | input | 1 | 1 = write command, 0 = read command |
| start_col | input | 8 | Start column of the command |
| len_sel | input | 3 | Burst length: 0=1, 1=2, 2=4, 3=8, 7=full row, others reserved |
| interleave | input | 1 | 1 = interleaved order, 0 = sequential order |
| single_write | input | 1 | 1 = writes are single-beat, reads use full length |
| suspend | input | 1 | Clock suspend: freeze the column counter this cycle |
| burst_stop | input | 1 | Terminate the current burst after this cycle |
| col | output | 8 | Column of the current beat |
| beat_valid | output | 1 | A beat is consumed at `col` this cycle |
| last_beat | output | 1 | This cycle closes the burst |

## Verification
Three control events can collide in one cycle: a burst stop with a clock suspend, and a new command with a burst stop. The bench holds `suspend` and `burst_stop` high together in mid-burst and expects `last_beat` high with `beat_valid` low, followed by an idle cycle; it then issues a fresh command in the same cycle as a burst stop and expects the burst to restart at the new column instead of going idle. Around these cases an exhaustive sweep covers every start column for each finite length in both orders.

// File: rtl/sdram_colgen_pkg.sv
package sdram_colgen_pkg;

  localparam int unsigned LEN_SEL_W = 3;

  typedef enum logic [LEN_SEL_W-1:0] {
    LEN_1    = 3'd0,
    LEN_2    = 3'd1,
    LEN_4    = 3'd2,
    LEN_8    = 3'd3,
    LEN_FULL = 3'd7
  } len_sel_e;

endpackage

// File: rtl/colgen_cfg_dec.sv
module colgen_cfg_dec
  import sdram_colgen_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic [LEN_SEL_W-1:0] len_sel,
  input  logic                 interleave,
  input  logic                 cmd_write,
  input  logic                 single_write,
  output logic                 cfg_ok,
  output logic                 cfg_full,
  output logic [COL_W-1:0]     cfg_mask
);

  logic             legal_len;
  logic             full_sel;
  logic [COL_W-1:0] len_mask;

  // Map the length code to a wrap mask (burst length minus one).
  always_comb begin
    legal_len = 1'b1;
    full_sel  = 1'b0;
    len_mask  = '0;
    case (len_sel)
      LEN_1:    len_mask = COL_W'(0);
      LEN_2:    len_mask = COL_W'(1);
      LEN_4:    len_mask = COL_W'(3);
      LEN_8:    len_mask = COL_W'(7);
      LEN_FULL: begin
        len_mask = '1;
        full_sel = 1'b1;
      end
      default:  legal_len = 1'b0;
    endcase
  end

  // Legality first, then the single-beat write override.
  always_comb begin
    cfg_ok   = legal_len & ~(full_sel & interleave);
    cfg_full = full_sel;
    cfg_mask = len_mask;
    if (cmd_write && single_write) begin
      cfg_full = 1'b0;
      cfg_mask = '0;
    end
  end

endmodule

// File: rtl/colgen_order.sv
module colgen_order #(
  parameter int unsigned COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] idx,
  input  logic [COL_W-1:0] mask,
  input  logic             interleave,
  output logic [COL_W-1:0] col
);

  logic [COL_W-1:0] low_part;

  always_comb begin
    if (interleave) begin
      low_part = base ^ idx;
    end else begin
      low_part = base + idx;
    end
    col = (base & ~mask) | (low_part & mask);
  end

endmodule

// File: rtl/colgen_beat_seq.sv
module colgen_beat_seq #(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [COL_W-1:0] load_col,
  input  logic [COL_W-1:0] load_mask,
  input  logic             load_full,
  input  logic             load_ilv,
  input  logic             stop,
  input  logic             hold,
  output logic             act_o,
  output logic             full_o,
  output logic             ilv_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] mask_o,
  output logic [COL_W-1:0] idx_o,
  output logic             final_o
);

  logic             act_q, act_d;
  logic             full_q, full_d;
  logic             ilv_q, ilv_d;
  logic [COL_W-1:0] base_q, base_d;
  logic [COL_W-1:0] mask_q, mask_d;
  logic [COL_W-1:0] idx_q, idx_d;
  logic             at_final;
  logic             en;

  assign at_final = act_q & ~full_q & (idx_q == mask_q);
  assign en       = load | (act_q & (stop | ~hold));

  always_comb begin
    act_d  = act_q;
    full_d = full_q;
    ilv_d  = ilv_q;
    base_d = base_q;
    mask_d = mask_q;
    idx_d  = idx_q;
    if (load) begin
      act_d  = 1'b1;
      full_d = load_full;
      ilv_d  = load_ilv;
      base_d = load_col;
      mask_d = load_mask;
      idx_d  = '0;
    end else if (act_q) begin
      if (stop) begin
        act_d = 1'b0;
      end else if (!hold) begin
        if (at_final) begin
          act_d = 1'b0;
        end else begin
          idx_d = idx_q + COL_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      full_q <= 1'b0;
      ilv_q  <= 1'b0;
      base_q <= '0;
      mask_q <= '0;
      idx_q  <= '0;
    end else if (en) begin
      act_q  <= act_d;
      full_q <= full_d;
      ilv_q  <= ilv_d;
      base_q <= base_d;
      mask_q <= mask_d;
      idx_q  <= idx_d;
    end
  end

  assign act_o   = act_q;
  assign full_o  = full_q;
  assign ilv_o   = ilv_q;
  assign base_o  = base_q;
  assign mask_o  = mask_q;
  assign idx_o   = idx_q;
  assign final_o = at_final;

endmodule

// File: rtl/sdram_col_gen.sv
module sdram_col_gen
  import sdram_colgen_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic                 cmd_write,
  input  logic [COL_W-1:0]     start_col,
  input  logic [LEN_SEL_W-1:0] len_sel,
  input  logic                 interleave,
  input  logic                 single_write,
  input  logic                 suspend,
  input  logic                 burst_stop,
  output logic [COL_W-1:0]     col,
  output logic                 beat_valid,
  output logic                 last_beat
);

  logic [1:0]       rst_pipe;
  logic             rst_q;
  logic             cfg_ok;
  logic             cfg_full;
  logic [COL_W-1:0] cfg_mask;
  logic             load;
  logic             act;
  logic             full;
  logic             ilv;
  logic [COL_W-1:0] base;
  logic [COL_W-1:0] mask;
  logic [COL_W-1:0] idx;
  logic             at_final;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_q = rst_pipe[1];

  colgen_cfg_dec #(.COL_W(COL_W)) u_dec (
    .len_sel      (len_sel),
    .interleave   (interleave),
    .cmd_write    (cmd_write),
    .single_write (single_write),
    .cfg_ok       (cfg_ok),
    .cfg_full     (cfg_full),
    .cfg_mask     (cfg_mask)
  );

  assign load = cmd_valid & cfg_ok;

  colgen_beat_seq #(.COL_W(COL_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_q),
    .load      (load),
    .load_col  (start_col),
    .load_mask (cfg_mask),
    .load_full (cfg_full),
    .load_ilv  (interleave),
    .stop      (burst_stop),
    .hold      (suspend),
    .act_o     (act),
    .full_o    (full),
    .ilv_o     (ilv),
    .base_o    (base),
    .mask_o    (mask),
    .idx_o     (idx),
    .final_o   (at_final)
  );

  colgen_order #(.COL_W(COL_W)) u_ord (
    .base       (base),
    .idx        (idx),
    .mask       (mask),
    .interleave (ilv),
    .col        (col)
  );

  assign beat_valid = act & ~suspend;
  assign last_beat  = act & (burst_stop | (~suspend & at_final));

endmodule

// File: rtl/sdram_col_gen_chk.sv
module sdram_col_gen_chk #(
  parameter int unsigned COL_W = 8
) (
  input logic             clk,
  input logic             rst_q,
  input logic             cmd_valid,
  input logic             cfg_ok,
  input logic [COL_W-1:0] start_col,
  input logic [2:0]       len_sel,
  input logic             interleave,
  input logic             suspend,
  input logic             burst_stop,
  input logic [COL_W-1:0] col,
  input logic             beat_valid,
  input logic             last_beat,
  input logic             act,
  input logic             full,
  input logic [COL_W-1:0] mask
);

  // R1
  always @(posedge clk) begin
    if (rst_q === 1'b0) begin
      rst_idle_chk: assert (!beat_valid && !last_beat);
    end
  end

  // R2
  start_col_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (cmd_valid && cfg_ok) |=> (col == $past(start_col)));

  // R3
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (act && !cmd_valid && !burst_stop && !last_beat) |=>
      ((col & ~mask) == $past(col & ~mask)));

  // R6
  full_nolast_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (act && full && !burst_stop) |-> !last_beat);

  // R7
  reject_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (cmd_valid && interleave && len_sel == 3'd7 && !act) |=> !act);

  // R9
  hold_col_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (act && suspend && !cmd_valid && !burst_stop) |=> $stable(col));

  // R10
  stop_end_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (act && burst_stop && !cmd_valid) |=> !act);

endmodule

bind sdram_col_gen sdram_col_gen_chk #(.COL_W(COL_W)) u_chk (
  .clk        (clk),
  .rst_q      (rst_q),
  .cmd_valid  (cmd_valid),
  .cfg_ok     (cfg_ok),
  .start_col  (start_col),
  .len_sel    (len_sel),
  .interleave (interleave),
  .suspend    (suspend),
  .burst_stop (burst_stop),
  .col        (col),
  .beat_valid (beat_valid),
  .last_beat  (last_beat),
  .act        (act),
  .full       (full),
  .mask       (mask)
);

// File: tb/sdram_col_gen_test.sv
module sdram_col_gen_test;

  logic       clk;
  logic       rst_n;
  logic       cmd_valid;
  logic       cmd_write;
  logic [7:0] start_col;
  logic [2:0] len_sel;
  logic       interleave;
  logic       single_write;
  logic       suspend;
  logic       burst_stop;
  logic [7:0] col;
  logic       beat_valid;
  logic       last_beat;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  sdram_col_gen uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_write    (cmd_write),
    .start_col    (start_col),
    .len_sel      (len_sel),
    .interleave   (interleave),
    .single_write (single_write),
    .suspend      (suspend),
    .burst_stop   (burst_stop),
    .col          (col),
    .beat_valid   (beat_valid),
    .last_beat    (last_beat)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_col(input logic [7:0] s, input logic [7:0] m,
                                         input logic ilv, input int k);
    logic [7:0] kk;
    kk = 8'(k);
    if (ilv) return s ^ kk;
    return (s & ~m) | ((s + kk) & m);
  endfunction

  task automatic idle_inputs();
    cmd_valid = 0; cmd_write = 0; start_col = 0; len_sel = 0;
    interleave = 0; single_write = 0; suspend = 0; burst_stop = 0;
  endtask

  task automatic issue(input logic [7:0] s, input logic [2:0] code, input logic ilv,
                       input logic wr, input logic sw);
    @(negedge clk);
    cmd_valid = 1; start_col = s; len_sel = code; interleave = ilv;
    cmd_write = wr; single_write = sw;
  endtask

  // Issue a command and check n beats, then one idle cycle.
  task automatic run_burst(input string tag, input logic [7:0] s, input logic [2:0] code,
                           input logic ilv, input logic wr, input logic sw,
                           input int n, input logic [7:0] m);
    issue(s, code, ilv, wr, sw);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cmd_valid = 0;
      #1;
      chk({tag, " col"}, col, exp_col(s, m, ilv, k));
      chk({tag, " valid"}, beat_valid, 1);
      chk({tag, " last"}, last_beat, (k == n - 1) ? 1 : 0);
    end
    @(negedge clk);
    #1;
    chk({tag, " idle after"}, beat_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 valid in reset", beat_valid, 0);
    chk("R1 last in reset", last_beat, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    #1;
    chk("R1 valid after reset", beat_valid, 0);

    // R2 R3 R4 R5 exhaustive finite sweep
    for (int code = 0; code < 4; code++) begin
      for (int t = 0; t < 2; t++) begin
        for (int s = 0; s < 256; s++) begin
          run_burst(t ? "R4 R5 ilv" : "R2 R3 R5 seq", 8'(s), 3'(code), t[0], 1'b0, 1'b0,
                    1 << code, 8'((1 << code) - 1));
        end
      end
    end

    // R8 single-beat write, read keeps length, write burst without the policy
    run_burst("R8 single write", 8'h33, 3'd3, 1'b0, 1'b1, 1'b1, 1, 8'h00);
    run_burst("R8 read keeps length", 8'h33, 3'd2, 1'b0, 1'b0, 1'b1, 4, 8'h03);
    run_burst("R8 burst write", 8'h33, 3'd1, 1'b0, 1'b1, 1'b0, 2, 8'h01);

    // R6 full row wrap, then R10 stop
    issue(8'd250, 3'd7, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      cmd_valid = 0;
      #1;
      chk("R6 full col", col, (250 + k) % 256);
      chk("R6 full no last", last_beat, 0);
    end
    @(negedge clk);
    burst_stop = 1;
    #1;
    chk("R10 stop last", last_beat, 1);
    chk("R10 stop col", col, (250 + 300) % 256);
    @(negedge clk);
    burst_stop = 0;
    #1;
    chk("R10 idle after stop", beat_valid, 0);

    // R7 illegal settings from idle
    issue(8'h12, 3'd7, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    cmd_valid = 0;
    #1;
    chk("R7 ilv full ignored", beat_valid, 0);
    issue(8'h12, 3'd5, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    cmd_valid = 0;
    #1;
    chk("R7 reserved ignored", beat_valid, 0);

    // R7 illegal command during a burst does not disturb it
    issue(8'h44, 3'd2, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    cmd_valid = 0;
    #1;
    chk("R7 mid beat0", col, 8'h44);
    @(negedge clk);
    cmd_valid = 1; start_col = 8'h90; len_sel = 3'd7; interleave = 1;
    #1;
    chk("R7 mid beat1", col, 8'h45);
    @(negedge clk);
    idle_inputs();
    #1;
    chk("R7 continues col", col, 8'h46);
    @(negedge clk);
    #1;
    chk("R7 continues last col", col, 8'h47);
    chk("R7 continues last", last_beat, 1);

    // R9 suspend: start 0x2D length 8 sequential
    issue(8'h2D, 3'd3, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    cmd_valid = 0;
    #1;
    chk("R9 beat0", col, 8'h2D);
    @(negedge clk);
    #1;
    chk("R9 beat1", col, 8'h2E);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      suspend = 1;
      #1;
      chk("R9 held col", col, 8'h2F);
      chk("R9 held valid", beat_valid, 0);
      chk("R9 held last", last_beat, 0);
    end
    @(negedge clk);
    suspend = 0;
    #1;
    chk("R9 resumed col", col, 8'h2F);
    chk("R9 resumed valid", beat_valid, 1);
    for (int k = 3; k < 8; k++) begin
      @(negedge clk);
      #1;
      chk("R9 rest col", col, exp_col(8'h2D, 8'h07, 1'b0, k));
      chk("R9 rest last", last_beat, (k == 7) ? 1 : 0);
    end

    // R10 stop and suspend in the same cycle
    issue(8'h00, 3'd3, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    cmd_valid = 0;
    @(negedge clk);
    @(negedge clk);
    suspend = 1; burst_stop = 1;
    #1;
    chk("R10 stop+suspend last", last_beat, 1);
    chk("R10 stop+suspend valid", beat_valid, 0);
    @(negedge clk);
    idle_inputs();
    #1;
    chk("R10 stop+suspend idle", beat_valid, 0);
    chk("R10 stop+suspend no last", last_beat, 0);

    // R11 new command with a simultaneous stop restarts
    issue(8'h10, 3'd2, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    cmd_valid = 0;
    @(negedge clk);
    cmd_valid = 1; start_col = 8'h81; len_sel = 3'd1; interleave = 1; burst_stop = 1;
    #1;
    chk("R11 old beat", col, 8'h11);
    @(negedge clk);
    idle_inputs();
    #1;
    chk("R11 restart col", col, 8'h81);
    chk("R11 restart valid", beat_valid, 1);
    @(negedge clk);
    #1;
    chk("R11 second col", col, 8'h80);
    chk("R11 second last", last_beat, 1);
    @(negedge clk);
    #1;
    chk("R11 idle", beat_valid, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule